// File: doc/BRIEF.md
# Multi-region flash sector locator

The block turns a byte offset inside a parallel flash into the global number of the sector that holds it, that sector's length and the sector's base address. The flash is described by up to four erase regions placed one after another. Each region has a block count and a sector length that is a power of two. Sector numbers continue across region boundaries, so the first sector of a region comes right after the last sector of the region before it.

The block also keeps one bit per sector that marks the sector as being erased. A mark port sets one bit, a clear port empties the whole map, and every lookup also reports the mark of the sector it found. An erase controller uses this to decide whether a read or program hits a sector that is busy.

The region layout and the chip size are captured while reset is asserted. The configuration is assumed to follow these rules: every sector length is a power of two, at least 256 and below 2^24; every region base is a multiple of that region's sector length; and the chip length is a power of two. A lookup is a one-cycle request with a registered answer. The answer is held in a three-state machine: `ST_IDLE` (no answer), `ST_HIT` (sector found) and `ST_MISS` (offset past the last region). The machine goes to `ST_HIT` on a request that lands in a region, to `ST_MISS` on a request that lands in no region, and to `ST_IDLE` in any cycle with no request. The state it leaves does not matter.

Top module: `loc_sector_locator`

## Requirements
- R1: Only the leading regions whose block count is nonzero take part. The first region with a zero count ends the list, and the regions after it are never matched, even when their counts are nonzero.
- R2: On a hit, `rsp_index` equals the sum of the block counts of all earlier regions plus (offset minus region base) shifted right by the region's log2 sector length, and `rsp_shift` equals that log2 length.
- R3: Before the lookup, the offset is reduced modulo 2^`cfg_chip_log2`, which keeps only its low `cfg_chip_log2` bits.
- R4: On a hit, `rsp_base` equals the reduced offset with every bit below the sector length cleared.
- R5: When the reduced offset lies beyond the end of the last active region, `rsp_err` is 1, and `rsp_index`, `rsp_shift`, `rsp_base` and `rsp_erasing` are all 0.
- R6: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_req` high, and 0 otherwise.
- R7: `mark_en` sets the erase bit of sector `mark_idx`. An index of `NSECT` or above changes nothing.
- R8: `clr_all` clears every erase bit. When it comes in the same cycle as `mark_en`, the clear wins.
- R9: `rsp_erasing` is the erase bit of the sector found, taken as it stood in the request cycle. A mark in that same cycle is not yet visible.
- R10: After reset, `rsp_valid` is 0 and no sector is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration captured while low |
| cfg_blocks | input | NREG*CNT_W | Block count per region, region 0 in the low bits |
| cfg_shifts | input | NREG*SH_W | log2 sector length per region, region 0 in the low bits |
| cfg_chip_log2 | input | SH_W | log2 of the chip length |
| lk_req | input | 1 | Lookup request |
| lk_offset | input | ADDR_W | Byte offset to look up |
| mark_en | input | 1 | Set the erase bit of `mark_idx` |
| mark_idx | input | SIDX_W | Sector to mark |
| clr_all | input | 1 | Clear every erase bit |
| rsp_valid | output | 1 | Answer present |
| rsp_err | output | 1 | Offset outside every region |
| rsp_index | output | SIDX_W | Global sector number |
| rsp_shift | output | SH_W | log2 sector length |
| rsp_base | output | ADDR_W | Sector base address |
| rsp_erasing | output | 1 | Erase bit of the found sector |

## Verification
On every cycle, the assertions check the one-cycle answer timing, the alignment of each reported base to its reported length, the zero payload of a miss, and how the erase map reacts to set and clear (including the clear winning over a set). Only the directed scenarios can show the numbers themselves. These are the sector indices summed across regions, the modulo reduction of the offset, the way a zero block count cuts off the later regions, and the rule that the erase bit is read before a mark made in the same cycle.

// File: rtl/loc_pkg.sv
package loc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } loc_state_e;
endpackage

// File: rtl/loc_region_map.sv
module loc_region_map #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8,
    parameter int SH_W   = 5,
    parameter int SIDX_W = 10
) (
    input  logic [NREG*CNT_W-1:0] blocks,
    input  logic [NREG*SH_W-1:0]  shifts,
    input  logic [SH_W-1:0]       chip_log2,
    input  logic [ADDR_W-1:0]     offset,
    output logic                  hit,
    output logic [SIDX_W-1:0]     sidx,
    output logic [SH_W-1:0]       shift,
    output logic [ADDR_W-1:0]     base
);
    localparam int SUM_W = ADDR_W + 2;

    logic [ADDR_W-1:0] chip_mask;
    logic [SUM_W-1:0]  moff;
    logic [SUM_W-1:0]  rbase [NREG+1];
    logic [SIDX_W-1:0] sbase [NREG+1];
    logic              act   [NREG+1];
    logic [NREG-1:0]   hit_v;
    logic [SIDX_W-1:0] idx_v [NREG];
    logic [SH_W-1:0]   sh_v  [NREG];

    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
        assign chip_mask[b] = (SH_W'(b) < chip_log2);
    end
    assign moff = SUM_W'(offset & chip_mask);

    assign rbase[0] = '0;
    assign sbase[0] = '0;
    assign act[0]   = 1'b1;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] rel;
        assign cnt        = blocks[i*CNT_W +: CNT_W];
        assign sh_v[i]    = shifts[i*SH_W +: SH_W];
        assign act[i+1]   = act[i] && (cnt != '0);
        assign rbase[i+1] = rbase[i] + (SUM_W'(cnt) << sh_v[i]);
        assign sbase[i+1] = sbase[i] + SIDX_W'(cnt);
        assign hit_v[i]   = act[i+1] && (moff >= rbase[i]) && (moff < rbase[i+1]);
        assign rel        = (moff - rbase[i]) >> sh_v[i];
        assign idx_v[i]   = sbase[i] + SIDX_W'(rel);
    end

    always_comb begin
        hit   = 1'b0;
        sidx  = '0;
        shift = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit   = 1'b1;
                sidx  = idx_v[i];
                shift = sh_v[i];
            end
        end
        base = ADDR_W'(moff) & ~((ADDR_W'(1) << shift) - ADDR_W'(1));
    end
endmodule

// File: rtl/loc_erase_map.sv
module loc_erase_map #(
    parameter int NSECT  = 64,
    parameter int SIDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [SIDX_W-1:0] set_idx,
    input  logic              clr_all,
    input  logic [SIDX_W-1:0] q_idx,
    output logic              q_bit,
    output logic [NSECT-1:0]  bits
);
    localparam int MI_W = (NSECT > 1) ? $clog2(NSECT) : 1;

    logic set_ok;
    assign set_ok = set_en && (set_idx < SIDX_W'(NSECT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (clr_all) begin
            bits <= '0;
        end else if (set_ok) begin
            bits[set_idx[MI_W-1:0]] <= 1'b1;
        end
    end

    assign q_bit = (q_idx < SIDX_W'(NSECT)) ? bits[q_idx[MI_W-1:0]] : 1'b0;
endmodule

// File: rtl/loc_sector_locator.sv
module loc_sector_locator #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8,
    parameter int NSECT  = 64,
    parameter int SH_W   = $clog2(ADDR_W + 1),
    parameter int SIDX_W = $clog2(NREG * (1 << CNT_W))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREG*CNT_W-1:0] cfg_blocks,
    input  logic [NREG*SH_W-1:0]  cfg_shifts,
    input  logic [SH_W-1:0]       cfg_chip_log2,
    input  logic                  lk_req,
    input  logic [ADDR_W-1:0]     lk_offset,
    input  logic                  mark_en,
    input  logic [SIDX_W-1:0]     mark_idx,
    input  logic                  clr_all,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [SIDX_W-1:0]     rsp_index,
    output logic [SH_W-1:0]       rsp_shift,
    output logic [ADDR_W-1:0]     rsp_base,
    output logic                  rsp_erasing
);
    import loc_pkg::*;

    logic [NREG*CNT_W-1:0] blocks_q;
    logic [NREG*SH_W-1:0]  shifts_q;
    logic [SH_W-1:0]       chip_log2_q;

    logic              m_hit;
    logic [SIDX_W-1:0] m_idx;
    logic [SH_W-1:0]   m_shift;
    logic [ADDR_W-1:0] m_base;
    logic              q_bit;
    logic [NSECT-1:0]  erase_bits;

    loc_state_e        state_q, state_d;
    logic [SIDX_W-1:0] idx_q;
    logic [SH_W-1:0]   shift_q;
    logic [ADDR_W-1:0] base_q;
    logic              eras_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blocks_q    <= cfg_blocks;
            shifts_q    <= cfg_shifts;
            chip_log2_q <= cfg_chip_log2;
        end
    end

    loc_region_map #(
        .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SH_W(SH_W), .SIDX_W(SIDX_W)
    ) map_i (
        .blocks(blocks_q), .shifts(shifts_q), .chip_log2(chip_log2_q),
        .offset(lk_offset), .hit(m_hit), .sidx(m_idx), .shift(m_shift), .base(m_base)
    );

    loc_erase_map #(.NSECT(NSECT), .SIDX_W(SIDX_W)) emap_i (
        .clk(clk), .rst_n(rst_n), .set_en(mark_en), .set_idx(mark_idx),
        .clr_all(clr_all), .q_idx(m_idx), .q_bit(q_bit), .bits(erase_bits)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (lk_req) state_d = m_hit ? ST_HIT : ST_MISS;
                else        state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            shift_q <= '0;
            base_q  <= '0;
            eras_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (lk_req) begin
                idx_q   <= m_hit ? m_idx   : '0;
                shift_q <= m_hit ? m_shift : '0;
                base_q  <= m_hit ? m_base  : '0;
                eras_q  <= m_hit && q_bit;
            end
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_err     = 1'b0;
        rsp_index   = '0;
        rsp_shift   = '0;
        rsp_base    = '0;
        rsp_erasing = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid   = 1'b1;
                rsp_index   = idx_q;
                rsp_shift   = shift_q;
                rsp_base    = base_q;
                rsp_erasing = eras_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/loc_sector_locator_chk.sv
module loc_sector_locator_chk #(
    parameter int ADDR_W = 24,
    parameter int NSECT  = 64,
    parameter int SH_W   = 5,
    parameter int SIDX_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic              mark_en,
    input logic [SIDX_W-1:0] mark_idx,
    input logic              clr_all,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [SIDX_W-1:0] rsp_index,
    input logic [SH_W-1:0]   rsp_shift,
    input logic [ADDR_W-1:0] rsp_base,
    input logic              rsp_erasing,
    input logic [NSECT-1:0]  erase_bits
);
    localparam int MI_W = (NSECT > 1) ? $clog2(NSECT) : 1;
    logic [MI_W-1:0] mark_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mark_q <= '0;
        else        mark_q <= mark_idx[MI_W-1:0];
    end

    p_valid_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    p_idle_without_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |->
            ((rsp_base & ((ADDR_W'(1) << rsp_shift) - ADDR_W'(1))) == '0));
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_index == '0 && rsp_base == '0 && !rsp_erasing));
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (erase_bits == '0));
    p_mark_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && !clr_all && mark_idx < SIDX_W'(NSECT)) |=> erase_bits[mark_q]);
    p_map_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_en && !clr_all) |=> $stable(erase_bits));
endmodule

bind loc_sector_locator loc_sector_locator_chk #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .SH_W(SH_W), .SIDX_W(SIDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .mark_en(mark_en),
    .mark_idx(mark_idx), .clr_all(clr_all), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_index(rsp_index), .rsp_shift(rsp_shift),
    .rsp_base(rsp_base), .rsp_erasing(rsp_erasing), .erase_bits(erase_bits)
);

// File: tb/loc_sector_locator_tb_top.sv
module loc_sector_locator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4, ADDR_W = 24, CNT_W = 8, NSECT = 64, SH_W = 5, SIDX_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREG*CNT_W-1:0] cfg_blocks = '0;
    logic [NREG*SH_W-1:0]  cfg_shifts = '0;
    logic [SH_W-1:0]       cfg_chip_log2 = '0;
    logic                  lk_req = 1'b0;
    logic [ADDR_W-1:0]     lk_offset = '0;
    logic                  mark_en = 1'b0;
    logic [SIDX_W-1:0]     mark_idx = '0;
    logic                  clr_all = 1'b0;
    logic                  rsp_valid, rsp_err, rsp_erasing;
    logic [SIDX_W-1:0]     rsp_index;
    logic [SH_W-1:0]       rsp_shift;
    logic [ADDR_W-1:0]     rsp_base;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loc_sector_locator #(.NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NSECT(NSECT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_blocks(cfg_blocks), .cfg_shifts(cfg_shifts),
        .cfg_chip_log2(cfg_chip_log2), .lk_req(lk_req), .lk_offset(lk_offset),
        .mark_en(mark_en), .mark_idx(mark_idx), .clr_all(clr_all),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_index(rsp_index),
        .rsp_shift(rsp_shift), .rsp_base(rsp_base), .rsp_erasing(rsp_erasing)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic restart(input logic [NREG*CNT_W-1:0] b, input logic [NREG*SH_W-1:0] s,
                           input logic [SH_W-1:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_blocks = b; cfg_shifts = s; cfg_chip_log2 = c;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one request cycle; answer sampled at the following falling edge
    task automatic lookup(input logic [ADDR_W-1:0] off);
        lk_offset = off;
        lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [ADDR_W-1:0] off,
                              input int idx, input int sh, input int base, input bit eras);
        lookup(off);
        check({req, " valid"}, 32'(rsp_valid), 1);
        check({req, " err"}, 32'(rsp_err), 0);
        check({req, " index"}, 32'(rsp_index), 32'(idx));
        check({req, " shift"}, 32'(rsp_shift), 32'(sh));
        check({req, " base"}, 32'(rsp_base), 32'(base));
        check({req, " erasing"}, 32'(rsp_erasing), 32'(eras));
    endtask

    task automatic expect_miss(input string req, input logic [ADDR_W-1:0] off);
        lookup(off);
        check({req, " valid"}, 32'(rsp_valid), 1);
        check({req, " err"}, 32'(rsp_err), 1);
        check({req, " index"}, 32'(rsp_index), 0);
        check({req, " base"}, 32'(rsp_base), 0);
    endtask

    task automatic mark(input int idx, input bit clr);
        mark_idx = SIDX_W'(idx); mark_en = 1'b1; clr_all = clr;
        @(negedge clk);
        mark_en = 1'b0; clr_all = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // layout: 4 x 4 KiB, 2 x 16 KiB, 1 x 16 KiB, chip 128 KiB
    localparam logic [NREG*CNT_W-1:0] BLK_A = {8'd0, 8'd1, 8'd2, 8'd4};
    localparam logic [NREG*SH_W-1:0]  SHF_A = {5'd0, 5'd14, 5'd14, 5'd12};
    localparam logic [NREG*CNT_W-1:0] BLK_B = {8'd0, 8'd1, 8'd0, 8'd4};

    task automatic t_reset_r10();
        restart(BLK_A, SHF_A, 5'd17);
        check("R10 valid after reset", 32'(rsp_valid), 0);
        expect_hit("R10 map empty", 24'h00C000, 6, 14, 24'h00C000, 1'b0);
    endtask

    task automatic t_lookup_r2_r4();
        expect_hit("R2 first sector", 24'h000000, 0, 12, 24'h000000, 1'b0);
        expect_hit("R4 last of region0", 24'h003FFF, 3, 12, 24'h003000, 1'b0);
        expect_hit("R2 start region1", 24'h004000, 4, 14, 24'h004000, 1'b0);
        expect_hit("R4 end region1", 24'h00BFFF, 5, 14, 24'h008000, 1'b0);
        expect_hit("R2 region2", 24'h00C123, 6, 14, 24'h00C000, 1'b0);
    endtask

    task automatic t_miss_r5();
        expect_miss("R5 past last region", 24'h012345);
        expect_miss("R5 top of chip", 24'h01FFFF);
    endtask

    task automatic t_modulo_r3();
        expect_hit("R3 wrap", 24'h021005, 1, 12, 24'h001000, 1'b0);
        expect_miss("R3 wrap to hole", 24'hF3FFFF);
    endtask

    task automatic t_latency_r6();
        lookup(24'h000100);
        check("R6 valid one cycle after", 32'(rsp_valid), 1);
        @(negedge clk);
        check("R6 idle without request", 32'(rsp_valid), 0);
    endtask

    task automatic t_erase_map();
        mark(5, 1'b0);
        expect_hit("R7 marked sector", 24'h008000, 5, 14, 24'h008000, 1'b1);
        expect_hit("R9 neighbour unmarked", 24'h004000, 4, 14, 24'h004000, 1'b0);
        mark(70, 1'b0);
        expect_hit("R7 out of range ignored", 24'h008000, 5, 14, 24'h008000, 1'b1);
        mark(4, 1'b1);
        expect_hit("R8 clear wins sector4", 24'h004000, 4, 14, 24'h004000, 1'b0);
        expect_hit("R8 clear wins sector5", 24'h008000, 5, 14, 24'h008000, 1'b0);
        // mark and lookup in the same cycle: old bit is reported
        mark_idx = SIDX_W'(6); mark_en = 1'b1;
        lookup(24'h00C000);
        mark_en = 1'b0;
        check("R9 same cycle mark not seen", 32'(rsp_erasing), 0);
        expect_hit("R9 mark seen next", 24'h00C000, 6, 14, 24'h00C000, 1'b1);
        mark(0, 1'b0);
        expect_miss("R5 miss no erasing", 24'h010000);
        check("R5 erasing zero", 32'(rsp_erasing), 0);
        clr_all = 1'b1; @(negedge clk); clr_all = 1'b0;
        expect_hit("R8 clear all", 24'h000000, 0, 12, 24'h000000, 1'b0);
    endtask

    task automatic t_leading_r1();
        restart(BLK_B, SHF_A, 5'd17);
        expect_hit("R1 region0 still active", 24'h000100, 0, 12, 24'h000000, 1'b0);
        expect_miss("R1 zero count ends list", 24'h004000);
        expect_miss("R1 later region unused", 24'h00C000);
    endtask

    initial begin
        t_reset_r10();
        t_lookup_r2_r4();
        t_miss_r5();
        t_modulo_r3();
        t_latency_r6();
        t_erase_map();
        t_leading_r1();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule